// File: doc/BRIEF.md
# Register Port Contention Picker

Several function units compete for the same register file ports. This block sits in front of one read port for the first source operand, one read port for the second source operand, and one write port. For each of these ports it decides which unit may use the port in the current cycle. Each unit holds a level "able to use the port" bit (`rd_ok` or `wr_ok`), which can stay high while the unit is idle. Each unit also holds a pending latch for each port. The latch is set by an issue pulse, and its output acts as the release qualifier. A unit is eligible for a port only when both its able bit and its pending latch are high.

Among the eligible units, a fixed-priority picker raises a single grant bit, and the lowest-numbered unit wins. The grant vector is combinational from the eligible vector. It drives the port enable in that cycle and loops back to clear the winner's pending latch at the next clock edge, so every grant lasts exactly one cycle. The three ports have fully independent latches and pickers. A unit that reads only one operand therefore never holds up traffic on the other operand port.

Top module: `rpcp_top`

## Requirements
- R1: A grant bit `go_*[i]` is high only while unit i's pending bit `pend_*[i]` and its able bit (`rd_ok[i]` for both read ports, `wr_ok[i]` for the write port) are both high.
- R2: On every port the grant vector is one-hot or all zero.
- R3: When several units are eligible on a port, the grant goes to the eligible unit with the lowest index (bit 0 is the highest priority).
- R4: When no unit is eligible on a port, that port's grant vector is all zero, even while able bits are high.
- R5: A grant clears the unit's pending bit at the next rising clock edge, so each issued request is granted exactly once, for a single cycle.
- R6: An issue pulse on `issue_*[i]` sets `pend_*[i]` at the next rising edge. The bit stays set until that unit is granted. An issue in the same cycle as that unit's grant keeps the bit set.
- R7: The first-operand, second-operand and write ports have separate pending bits and pickers, so one port's grants never depend on another port's requests.
- R8: Each port enable `en_*` is high exactly in the cycles when that port's grant vector is non-zero.
- R9: While `rst_n` is low, every pending bit is cleared and every grant and enable is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_rd1 | input | N | Issue pulses for the first-operand read port, one bit per unit |
| issue_rd2 | input | N | Issue pulses for the second-operand read port |
| issue_wr | input | N | Issue pulses for the write port |
| rd_ok | input | N | Level bit per unit: the unit is able to take operands |
| wr_ok | input | N | Level bit per unit: the unit is able to store a result |
| go_rd1 | output | N | One-hot grant for the first-operand read port |
| go_rd2 | output | N | One-hot grant for the second-operand read port |
| go_wr | output | N | One-hot grant for the write port |
| pend_rd1 | output | N | Pending/release bits for the first-operand read port |
| pend_rd2 | output | N | Pending/release bits for the second-operand read port |
| pend_wr | output | N | Pending/release bits for the write port |
| en_rd1 | output | 1 | First-operand read port enable |
| en_rd2 | output | 1 | Second-operand read port enable |
| en_wr | output | 1 | Write port enable |

## Verification
A lone request on one unit shows the basic set, grant and clear loop, with a single-cycle grant and no grant afterwards. Simultaneous requests from two units, and from all four, separate a correct priority order from a wrong one, and the count of grants per unit shows each request served exactly once. Able bits held high with no pending request, and pending requests with the able bit held low, separate the two qualifiers from each other. Requests on disjoint ports in the same cycle show that the three pickers do not interact. Re-issuing a request during its own grant cycle shows that a set takes precedence over a clear.

// File: rtl/rpcp_pkg.sv
package rpcp_pkg;

   // Number of arbitrated ports: first operand read, second operand read, write.
   localparam int unsigned NUM_PORTS = 3;

   // Implementation variant of the fixed-priority picker.
   typedef enum logic [0:0] {
      PICK_RIPPLE  = 1'b0,   // linear "seen" chain, lowest index first
      PICK_ISOLATE = 1'b1    // two's-complement lowest-set-bit isolate
   } pick_arch_e;

endpackage

// File: rtl/rpcp_req_latch.sv
module rpcp_req_latch #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] held_o
);

   if (N < 1) begin : g_bad_n
      $error("rpcp_req_latch: N must be at least 1");
   end

   // One independent pending flop per unit; a set wins over a clear.
   for (genvar u = 0; u < N; u++) begin : g_unit
      logic held_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            held_q <= 1'b0;
         else if (set_i[u])
            held_q <= 1'b1;
         else if (clr_i[u])
            held_q <= 1'b0;
      end
      assign held_o[u] = held_q;
   end

endmodule

// File: rtl/rpcp_prio_pick.sv
module rpcp_prio_pick
   import rpcp_pkg::*;
#(
   parameter int unsigned N    = 4,
   parameter pick_arch_e  ARCH = PICK_RIPPLE
) (
   input  logic [N-1:0] elig_i,
   output logic [N-1:0] grant_o
);

   if (N < 1) begin : g_bad_n
      $error("rpcp_prio_pick: N must be at least 1");
   end

   if (ARCH == PICK_RIPPLE) begin : g_ripple
      always_comb begin
         logic seen;
         seen    = 1'b0;
         grant_o = '0;
         for (int i = 0; i < int'(N); i++) begin
            grant_o[i] = elig_i[i] & ~seen;
            seen       = seen | elig_i[i];
         end
      end
   end else begin : g_isolate
      logic [N-1:0] neg;
      assign neg     = (~elig_i) + {{(N-1){1'b0}}, 1'b1};
      assign grant_o = elig_i & neg;
   end

endmodule

// File: rtl/rpcp_port_lane.sv
module rpcp_port_lane
   import rpcp_pkg::*;
#(
   parameter int unsigned N    = 4,
   parameter pick_arch_e  ARCH = PICK_RIPPLE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] issue_i,
   input  logic [N-1:0] able_i,
   output logic [N-1:0] go_o,
   output logic [N-1:0] pend_o,
   output logic         en_o
);

   logic [N-1:0] held;
   logic [N-1:0] elig;
   logic [N-1:0] grant;

   rpcp_req_latch #(.N(N)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (issue_i),
      .clr_i  (grant),
      .held_o (held)
   );

   // Release qualifier: the latch output; able level alone is not enough.
   assign elig = held & able_i;

   rpcp_prio_pick #(.N(N), .ARCH(ARCH)) u_pick (
      .elig_i  (elig),
      .grant_o (grant)
   );

   assign go_o   = grant;
   assign pend_o = held;
   assign en_o   = |grant;

endmodule

// File: rtl/rpcp_top.sv
module rpcp_top
   import rpcp_pkg::*;
#(
   parameter int unsigned N        = 4,
   parameter pick_arch_e  RD_ARCH  = PICK_RIPPLE,
   parameter pick_arch_e  WR_ARCH  = PICK_ISOLATE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] issue_rd1,
   input  logic [N-1:0] issue_rd2,
   input  logic [N-1:0] issue_wr,
   input  logic [N-1:0] rd_ok,
   input  logic [N-1:0] wr_ok,
   output logic [N-1:0] go_rd1,
   output logic [N-1:0] go_rd2,
   output logic [N-1:0] go_wr,
   output logic [N-1:0] pend_rd1,
   output logic [N-1:0] pend_rd2,
   output logic [N-1:0] pend_wr,
   output logic         en_rd1,
   output logic         en_rd2,
   output logic         en_wr
);

   localparam int unsigned LAST_WR = NUM_PORTS - 1;

   if (N < 1) begin : g_bad_n
      $error("rpcp_top: N must be at least 1");
   end

   logic [NUM_PORTS-1:0][N-1:0] issue_v;
   logic [NUM_PORTS-1:0][N-1:0] able_v;
   logic [NUM_PORTS-1:0][N-1:0] go_v;
   logic [NUM_PORTS-1:0][N-1:0] pend_v;
   logic [NUM_PORTS-1:0]        en_v;

   assign issue_v = {issue_wr, issue_rd2, issue_rd1};
   assign able_v  = {wr_ok, rd_ok, rd_ok};

   // One fully independent lane per port; the write lane may use another variant.
   for (genvar p = 0; p < int'(NUM_PORTS); p++) begin : g_lane
      localparam pick_arch_e LANE_ARCH = (p == int'(LAST_WR)) ? WR_ARCH : RD_ARCH;
      rpcp_port_lane #(.N(N), .ARCH(LANE_ARCH)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .issue_i (issue_v[p]),
         .able_i  (able_v[p]),
         .go_o    (go_v[p]),
         .pend_o  (pend_v[p]),
         .en_o    (en_v[p])
      );
   end

   assign go_rd1   = go_v[0];
   assign go_rd2   = go_v[1];
   assign go_wr    = go_v[2];
   assign pend_rd1 = pend_v[0];
   assign pend_rd2 = pend_v[1];
   assign pend_wr  = pend_v[2];
   assign en_rd1   = en_v[0];
   assign en_rd2   = en_v[1];
   assign en_wr    = en_v[2];

endmodule

// File: rtl/rpcp_chk.sv
module rpcp_chk #(
   parameter int unsigned N = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic [N-1:0] ok,
   input logic [N-1:0] issue,
   input logic [N-1:0] pend,
   input logic [N-1:0] go,
   input logic         en
);

   AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (go & ~(pend & ok)) == '0); // R1
   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(go)); // R2
   AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (go != '0) |-> ((pend & ok & (go - 1'b1)) == '0)); // R3
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & ok) == '0) |-> (go == '0)); // R4
   AST_GRANT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ((go & ~issue) != '0) |=> ((pend & $past(go & ~issue)) == '0)); // R5
   AST_ISSUE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (issue != '0) |=> ((pend & $past(issue)) == $past(issue))); // R6
   AST_ENABLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      en == (go != '0)); // R8

endmodule

bind rpcp_top rpcp_chk #(.N(N)) u_chk_rd1 (
   .clk(clk), .rst_n(rst_n), .ok(rd_ok), .issue(issue_rd1),
   .pend(pend_rd1), .go(go_rd1), .en(en_rd1));
bind rpcp_top rpcp_chk #(.N(N)) u_chk_rd2 (
   .clk(clk), .rst_n(rst_n), .ok(rd_ok), .issue(issue_rd2),
   .pend(pend_rd2), .go(go_rd2), .en(en_rd2));
bind rpcp_top rpcp_chk #(.N(N)) u_chk_wr (
   .clk(clk), .rst_n(rst_n), .ok(wr_ok), .issue(issue_wr),
   .pend(pend_wr), .go(go_wr), .en(en_wr));

// File: tb/rpcp_top_tb_top.sv
module rpcp_top_tb_top;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] issue_rd1 = '0, issue_rd2 = '0, issue_wr = '0;
   logic [N-1:0] rd_ok = '1, wr_ok = '1;
   logic [N-1:0] go_rd1, go_rd2, go_wr, pend_rd1, pend_rd2, pend_wr;
   logic         en_rd1, en_rd2, en_wr;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   rpcp_top #(.N(N)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .issue_rd1(issue_rd1), .issue_rd2(issue_rd2), .issue_wr(issue_wr),
      .rd_ok(rd_ok), .wr_ok(wr_ok),
      .go_rd1(go_rd1), .go_rd2(go_rd2), .go_wr(go_wr),
      .pend_rd1(pend_rd1), .pend_rd2(pend_rd2), .pend_wr(pend_wr),
      .en_rd1(en_rd1), .en_rd2(en_rd2), .en_wr(en_wr));

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Advance to the next falling edge, then let combinational logic settle.
   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      issue_rd1 = '1; issue_rd2 = '1; issue_wr = '1;
      repeat (2) tick();
      check("R9", "pend_rd1 in reset", pend_rd1, 0);
      check("R9", "pend_wr in reset", pend_wr, 0);
      check("R9", "go_rd2 in reset", go_rd2, 0);
      check("R9", "en_wr in reset", en_wr, 0);
      issue_rd1 = '0; issue_rd2 = '0; issue_wr = '0;
      rst_n = 1'b1;
      tick();
   endtask

   task automatic t_single();
      issue_rd1 = 4'b0100;
      tick();
      issue_rd1 = '0;
      check("R6", "pend_rd1 after issue", pend_rd1, 4'b0100);
      check("R1", "go_rd1 single", go_rd1, 4'b0100);
      check("R8", "en_rd1 during grant", en_rd1, 1);
      check("R7", "go_rd2 untouched", go_rd2, 0);
      tick();
      check("R5", "go_rd1 one cycle", go_rd1, 0);
      check("R5", "pend_rd1 cleared", pend_rd1, 0);
      check("R8", "en_rd1 after grant", en_rd1, 0);
   endtask

   task automatic t_priority();
      issue_rd2 = 4'b1010;
      tick();
      issue_rd2 = '0;
      check("R3", "go_rd2 first winner", go_rd2, 4'b0010);
      check("R2", "go_rd2 onehot", $countones(go_rd2), 1);
      tick();
      check("R3", "go_rd2 second winner", go_rd2, 4'b1000);
      check("R5", "pend_rd2 unit1 gone", pend_rd2, 4'b1000);
      tick();
      check("R4", "go_rd2 drained", go_rd2, 0);
   endtask

   task automatic t_qualify();
      rd_ok = '1;
      repeat (2) tick();
      check("R4", "able without pending", go_rd1, 0);
      rd_ok = 4'b1110;
      issue_rd1 = 4'b0001;
      tick();
      issue_rd1 = '0;
      check("R1", "pending without able", go_rd1, 0);
      tick();
      check("R1", "pending held while not able", pend_rd1, 4'b0001);
      rd_ok = '1;
      #1;
      check("R1", "grant once able", go_rd1, 4'b0001);
      tick();
      check("R5", "cleared after late grant", pend_rd1, 0);
   endtask

   task automatic t_independent();
      issue_rd1 = 4'b0001;
      issue_rd2 = 4'b0010;
      issue_wr  = 4'b0001;
      tick();
      issue_rd1 = '0; issue_rd2 = '0; issue_wr = '0;
      check("R7", "go_rd1 parallel", go_rd1, 4'b0001);
      check("R7", "go_rd2 parallel", go_rd2, 4'b0010);
      check("R7", "go_wr parallel", go_wr, 4'b0001);
      check("R8", "all enables", {en_rd1, en_rd2, en_wr}, 3'b111);
      tick();
   endtask

   task automatic t_write_all();
      int cnt [N];
      logic [N-1:0] order [N];
      for (int k = 0; k < N; k++) cnt[k] = 0;
      issue_wr = '1;
      tick();
      issue_wr = '0;
      for (int c = 0; c < N + 2; c++) begin
         if (c < N) order[c] = go_wr;
         for (int k = 0; k < N; k++) if (go_wr[k]) cnt[k]++;
         if ($countones(go_wr) > 1) check("R2", "go_wr onehot", go_wr, 0);
         tick();
      end
      for (int k = 0; k < N; k++) begin
         check("R3", "write order", order[k], 32'(1) << k);
         check("R5", "write granted once", cnt[k], 1);
      end
      check("R4", "write drained", go_wr, 0);
   endtask

   task automatic t_reissue();
      issue_rd1 = 4'b0001;
      tick();
      check("R6", "grant with re-issue", go_rd1, 4'b0001);
      tick();
      issue_rd1 = '0;
      check("R6", "set wins over clear", pend_rd1, 4'b0001);
      check("R6", "second grant", go_rd1, 4'b0001);
      tick();
      check("R5", "cleared after re-issue", pend_rd1, 0);
   endtask

   initial begin
      #1;
      t_reset();
      t_single();
      t_priority();
      t_qualify();
      t_independent();
      t_write_all();
      t_reissue();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule